// File: doc/BRIEF.md
# Dual-Direction Processor Mailbox

This block lets a host processor and an embedded DSP core pass commands and data to each other through two one-way mailboxes. Each side has its own simple synchronous register port with address, write enable, read enable, write data and read data. Each side also has one interrupt output. Each mailbox holds eight 16-bit data words, a 16-bit general word, an 8-bit command and a busy flag. The side that sends a message fills the data words first and then writes the command. That write sets the busy flag and interrupts the receiving side.

The receiver reads the message through its own port. Reading the command withdraws its interrupt. Writing to the busy flag releases the mailbox back to the sender. The block never locks out a write. Keeping to the busy handshake is the job of software.

The port address has a bank bit and an offset field. The bank bit is the top address bit. Bank 0 is the outgoing mailbox, the one this port writes. Bank 1 is the incoming mailbox, the one the peer writes. The offset field is the lower four bits:

| Offset | Register |
|---|---|
| 0 to 7 | data words |
| 8 | general word |
| 9 | command (low 8 bits) |
| 10 | busy flag (bit 0) |

Top module: `mbox_pair`

## Requirements
- R1: After reset, every mailbox register and both busy flags read 0, and both interrupt outputs are 0.
- R2: A write to outgoing offsets 0 to 9 (bank 0) stores the value. Only the low 8 bits of a command are stored. The peer reads the value at the same offset with the bank bit set. Read data appears in the cycle after the read enable and holds until the next read.
- R3: A host write to offset 0x09 sets the host-to-DSP busy flag and raises the DSP interrupt on the next clock edge. The flag reads 1 at host address 0x0A and at DSP address 0x1A.
- R4: A DSP read of address 0x19 returns the command and clears the DSP interrupt on the next edge. It leaves the busy flag unchanged.
- R5: The host-to-DSP busy flag is cleared only by a DSP write to address 0x1A. A host write to 0x0A leaves it unchanged.
- R6: A DSP write to its offset 0x09 sets the DSP-to-host busy flag and raises the host interrupt. A host read of 0x19 clears the host interrupt.
- R7: A host write to 0x1A clears the DSP-to-host busy flag. The DSP sees this as 0 at address 0x0A.
- R8: If a command write and a busy-clear write to the same mailbox fall in the same cycle, the busy flag ends at 1.
- R9: Writes are accepted while busy is 1 and overwrite the stored value.
- R10: A write to an incoming-bank offset other than 10 is ignored.
- R11: Offsets 11 to 15 read as 0 in either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low reset, synchronous |
| hostAddr | input | 5 | host register address |
| hostWe | input | 1 | host write enable |
| hostRe | input | 1 | host read enable |
| hostWdata | input | 16 | host write data |
| hostRdata | output | 16 | host read data, one cycle after read enable |
| hostIrq | output | 1 | interrupt to host, DSP-to-host message waiting |
| dspAddr | input | 5 | DSP register address |
| dspWe | input | 1 | DSP write enable |
| dspRe | input | 1 | DSP read enable |
| dspWdata | input | 16 | DSP write data |
| dspRdata | output | 16 | DSP read data, one cycle after read enable |
| dspIrq | output | 1 | interrupt to DSP, host-to-DSP message waiting |

## Verification
A busy flag or interrupt bit with the wrong value shows on the interrupt pin on the very next edge. A busy poll returns it one cycle after the read enable. A storage or decode fault shows as a wrong word in the receiver's read data one cycle after the read. The same fault can also show as a change in the receiver's copy after a write that should have been ignored. The bench polls both busy views and both interrupt pins after every command, read and clear. It also checks the same-cycle set and clear case, where a wrong priority would drop the flag at once.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int MB_DATA_W   = 16;
  parameter int MB_NUM_DATA = 8;
  parameter int MB_CMD_W    = 8;

  localparam int IDX_W  = $clog2(MB_NUM_DATA);
  localparam int OFF_W  = $clog2(MB_NUM_DATA + 3);
  localparam int ADDR_W = OFF_W + 1;

  localparam logic [OFF_W-1:0] OFF_GEN  = OFF_W'(MB_NUM_DATA);
  localparam logic [OFF_W-1:0] OFF_CMD  = OFF_W'(MB_NUM_DATA + 1);
  localparam logic [OFF_W-1:0] OFF_BUSY = OFF_W'(MB_NUM_DATA + 2);

  // write strobes for one mailbox direction
  typedef struct packed {
    logic             dataWe;
    logic             genWe;
    logic             cmdWe;
    logic [IDX_W-1:0] idx;
  } mbox_wr_t;

  // read request from one port
  typedef struct packed {
    logic             re;
    logic             dir;
    logic [OFF_W-1:0] off;
  } mbox_rd_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             we,
  input  logic [1:0]             re,
  input  logic [1:0][ADDR_W-1:0] addr,
  output mbox_wr_t [1:0]         wrStb,
  output mbox_rd_t [1:0]         rdStb,
  output logic [1:0]             busy,
  output logic [1:0]             irq
);
  logic [1:0] bankIn;
  logic [1:0][OFF_W-1:0] off;
  logic [1:0] cmdWr, busyClr, cmdRd;

  // direction d is written by port d and consumed by the other port
  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int PEER = 1 - d;

    assign bankIn[d] = addr[d][ADDR_W-1];
    assign off[d]    = addr[d][OFF_W-1:0];

    always_comb begin
      wrStb[d].dataWe = we[d] && !bankIn[d] && (off[d] < OFF_GEN);
      wrStb[d].genWe  = we[d] && !bankIn[d] && (off[d] == OFF_GEN);
      wrStb[d].cmdWe  = we[d] && !bankIn[d] && (off[d] == OFF_CMD);
      wrStb[d].idx    = off[d][IDX_W-1:0];
      rdStb[d].re     = re[d];
      rdStb[d].dir    = bankIn[d] ^ 1'(d);
      rdStb[d].off    = off[d];
    end

    assign cmdWr[d]   = wrStb[d].cmdWe;
    assign busyClr[d] = we[PEER] && bankIn[PEER] && (off[PEER] == OFF_BUSY);
    assign cmdRd[d]   = re[PEER] && bankIn[PEER] && (off[PEER] == OFF_CMD);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy[d] <= 1'b0;
        irq[d]  <= 1'b0;
      end else begin
        if (cmdWr[d])        busy[d] <= 1'b1;
        else if (busyClr[d]) busy[d] <= 1'b0;
        if (cmdWr[d])        irq[d]  <= 1'b1;
        else if (cmdRd[d])   irq[d]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  mbox_wr_t [1:0]            wrStb,
  input  mbox_rd_t [1:0]            rdStb,
  input  logic [1:0][MB_DATA_W-1:0] wdata,
  input  logic [1:0]                busy,
  output logic [1:0][MB_DATA_W-1:0] rdata
);
  logic [1:0][MB_NUM_DATA-1:0][MB_DATA_W-1:0] dataQ;
  logic [1:0][MB_DATA_W-1:0]                  genQ;
  logic [1:0][MB_CMD_W-1:0]                   cmdQ;
  logic [1:0][MB_DATA_W-1:0]                  rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      genQ  <= '0;
      cmdQ  <= '0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (wrStb[d].dataWe) dataQ[d][wrStb[d].idx] <= wdata[d];
        if (wrStb[d].genWe)  genQ[d] <= wdata[d];
        if (wrStb[d].cmdWe)  cmdQ[d] <= wdata[d][MB_CMD_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      rdNext[p] = '0;
      if (rdStb[p].off < OFF_GEN)
        rdNext[p] = dataQ[rdStb[p].dir][rdStb[p].off[IDX_W-1:0]];
      else if (rdStb[p].off == OFF_GEN)
        rdNext[p] = genQ[rdStb[p].dir];
      else if (rdStb[p].off == OFF_CMD)
        rdNext[p] = MB_DATA_W'(cmdQ[rdStb[p].dir]);
      else if (rdStb[p].off == OFF_BUSY)
        rdNext[p] = MB_DATA_W'(busy[rdStb[p].dir]);
    end

    always_ff @(posedge clk) begin
      if (!rstN)            rdata[p] <= '0;
      else if (rdStb[p].re) rdata[p] <= rdNext[p];
    end
  end
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic                 hostWe,
  input  logic                 hostRe,
  input  logic [MB_DATA_W-1:0] hostWdata,
  output logic [MB_DATA_W-1:0] hostRdata,
  output logic                 hostIrq,
  input  logic [ADDR_W-1:0]    dspAddr,
  input  logic                 dspWe,
  input  logic                 dspRe,
  input  logic [MB_DATA_W-1:0] dspWdata,
  output logic [MB_DATA_W-1:0] dspRdata,
  output logic                 dspIrq
);
  mbox_wr_t [1:0] wrStb;
  mbox_rd_t [1:0] rdStb;
  logic [1:0] busyVec, irqVec;
  logic [1:0][MB_DATA_W-1:0] rdVec;

  // index 0: host port / host-to-DSP mailbox, index 1: DSP port / DSP-to-host mailbox
  mbox_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .we    ({dspWe, hostWe}),
    .re    ({dspRe, hostRe}),
    .addr  ({dspAddr, hostAddr}),
    .wrStb (wrStb),
    .rdStb (rdStb),
    .busy  (busyVec),
    .irq   (irqVec)
  );

  mbox_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wrStb (wrStb),
    .rdStb (rdStb),
    .wdata ({dspWdata, hostWdata}),
    .busy  (busyVec),
    .rdata (rdVec)
  );

  assign hostRdata = rdVec[0];
  assign dspRdata  = rdVec[1];
  assign dspIrq    = irqVec[0];
  assign hostIrq   = irqVec[1];
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] hostAddr,
  input logic       hostWe,
  input logic [4:0] dspAddr,
  input logic       dspWe,
  input logic       dspRe,
  input logic       hostRe,
  input logic       hostIrq,
  input logic       dspIrq,
  input logic [1:0] busyVec
);
  AST_HOST_CMD_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == 5'h09) |=> dspIrq); // R3

  AST_DSP_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dspRe && dspAddr == 5'h19 && !(hostWe && hostAddr == 5'h09)) |=> !dspIrq); // R4

  AST_H2D_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busyVec[0] && !(dspWe && dspAddr == 5'h1A)) |=> busyVec[0]); // R5

  AST_DSP_CMD_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (dspWe && dspAddr == 5'h09) |=> (hostIrq && busyVec[1])); // R6

  AST_HOST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostRe && hostAddr == 5'h19 && !(dspWe && dspAddr == 5'h09)) |=> !hostIrq); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == 5'h09 && dspWe && dspAddr == 5'h1A) |=> busyVec[0]); // R8
endmodule

bind mbox_pair mbox_pair_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostAddr (hostAddr),
  .hostWe   (hostWe),
  .dspAddr  (dspAddr),
  .dspWe    (dspWe),
  .dspRe    (dspRe),
  .hostRe   (hostRe),
  .hostIrq  (hostIrq),
  .dspIrq   (dspIrq),
  .busyVec  (busyVec)
);

// File: tb/mbox_pair_tb.sv
`timescale 1ns/1ps
module mbox_pair_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] hostAddr = '0, dspAddr = '0;
  logic hostWe = 1'b0, hostRe = 1'b0, dspWe = 1'b0, dspRe = 1'b0;
  logic [15:0] hostWdata = '0, dspWdata = '0;
  logic [15:0] hostRdata, dspRdata;
  logic hostIrq, dspIrq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp; string req; logic [4:0] addr; } item_t;
  item_t hq[$], dq[$];

  always #10 clk = ~clk;

  mbox_pair u_dut (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostRe(hostRe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostIrq(hostIrq),
    .dspAddr(dspAddr), .dspWe(dspWe), .dspRe(dspRe),
    .dspWdata(dspWdata), .dspRdata(dspRdata), .dspIrq(dspIrq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitors: pop expected item when a read completes
  always @(posedge clk) begin : monHost
    logic was;
    item_t it;
    was = hostRe && rstN;
    #2;
    if (was) begin
      if (hq.size() == 0) check("host-queue", 16'h1, 16'h0);
      else begin it = hq.pop_front(); check(it.req, hostRdata, it.exp); end
    end
  end

  always @(posedge clk) begin : monDsp
    logic was;
    item_t it;
    was = dspRe && rstN;
    #2;
    if (was) begin
      if (dq.size() == 0) check("dsp-queue", 16'h1, 16'h0);
      else begin it = dq.pop_front(); check(it.req, dspRdata, it.exp); end
    end
  end

  // drivers, entered and left at the falling edge
  task automatic hWr(logic [4:0] a, logic [15:0] v);
    hostAddr = a; hostWdata = v; hostWe = 1'b1;
    @(negedge clk); hostWe = 1'b0;
  endtask
  task automatic dWr(logic [4:0] a, logic [15:0] v);
    dspAddr = a; dspWdata = v; dspWe = 1'b1;
    @(negedge clk); dspWe = 1'b0;
  endtask
  task automatic hRd(logic [4:0] a, logic [15:0] e, string req);
    hq.push_back('{e, req, a});
    hostAddr = a; hostRe = 1'b1;
    @(negedge clk); hostRe = 1'b0;
  endtask
  task automatic dRd(logic [4:0] a, logic [15:0] e, string req);
    dq.push_back('{e, req, a});
    dspAddr = a; dspRe = 1'b1;
    @(negedge clk); dspRe = 1'b0;
  endtask
  task automatic irqCheck(logic expH, logic expD, string req);
    check({req, " hostIrq"}, 16'(hostIrq), 16'(expH));
    check({req, " dspIrq"}, 16'(dspIrq), 16'(expD));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    irqCheck(1'b0, 1'b0, "R1");
    hRd(5'h0A, 16'h0, "R1 h2d busy");
    hRd(5'h10, 16'h0, "R1 d2h data0");
    dRd(5'h08, 16'h0, "R1 d2h gen");
    dRd(5'h19, 16'h0, "R1 h2d cmd");
    // R2 host fills its mailbox
    for (int i = 0; i < 8; i++) hWr(5'(i), 16'hA000 + 16'(i) * 16'h0111);
    hWr(5'h08, 16'h5A5A);
    irqCheck(1'b0, 1'b0, "R2 no irq before cmd");
    hWr(5'h09, 16'hFF3C);
    // R3
    irqCheck(1'b0, 1'b1, "R3");
    hRd(5'h0A, 16'h1, "R3 busy host view");
    dRd(5'h1A, 16'h1, "R3 busy dsp view");
    for (int i = 0; i < 8; i++) dRd(5'h10 + 5'(i), 16'hA000 + 16'(i) * 16'h0111, "R2 data");
    dRd(5'h18, 16'h5A5A, "R2 gen");
    // R4
    dRd(5'h19, 16'h003C, "R2 R4 cmd");
    irqCheck(1'b0, 1'b0, "R4");
    hRd(5'h0A, 16'h1, "R4 busy kept");
    // R5
    hWr(5'h0A, 16'h0);
    hRd(5'h0A, 16'h1, "R5 host write ignored");
    dWr(5'h1A, 16'h0);
    hRd(5'h0A, 16'h0, "R5 dsp clears");
    // R6
    dWr(5'h03, 16'hB003);
    dWr(5'h08, 16'hC0DE);
    dWr(5'h09, 16'h0081);
    irqCheck(1'b1, 1'b0, "R6");
    dRd(5'h0A, 16'h1, "R6 busy dsp view");
    hRd(5'h13, 16'hB003, "R6 data3");
    hRd(5'h18, 16'hC0DE, "R6 gen");
    hRd(5'h19, 16'h0081, "R6 cmd");
    irqCheck(1'b0, 1'b0, "R6 cleared");
    // R7
    hWr(5'h1A, 16'h0);
    dRd(5'h0A, 16'h0, "R7 busy cleared");
    hRd(5'h1A, 16'h0, "R7 host view");
    // R8 command and clear in the same cycle
    hostAddr = 5'h09; hostWdata = 16'h0011; hostWe = 1'b1;
    dspAddr = 5'h1A; dspWdata = 16'h0; dspWe = 1'b1;
    @(negedge clk); hostWe = 1'b0; dspWe = 1'b0;
    hRd(5'h0A, 16'h1, "R8 set wins");
    irqCheck(1'b0, 1'b1, "R8");
    // R9 overwrite while busy
    hWr(5'h00, 16'h1234);
    dRd(5'h10, 16'h1234, "R9 overwrite");
    // R10 incoming-bank writes ignored
    hWr(5'h13, 16'hDEAD);
    hRd(5'h13, 16'hB003, "R10 data ignored");
    dWr(5'h19, 16'h00EE);
    dRd(5'h19, 16'h0011, "R10 cmd ignored");
    irqCheck(1'b0, 1'b0, "R10 no host irq");
    // R11 unmapped
    hRd(5'h0F, 16'h0, "R11 bank0");
    dRd(5'h1C, 16'h0, "R11 bank1");
    repeat (2) @(negedge clk);
    check("R1-queue-empty", 16'(hq.size() + dq.size()), 16'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule